// File: doc/BRIEF.md
# I2C Master Command-List Sequencer

This block drives an I2C master from a small stored program. Software writes up to sixteen command words, each one naming an operation, a byte count and how to treat the acknowledge bit. It then pulses a start input. The sequencer walks the list from entry 0. For every step it asks a separate bit-level engine for a START, a STOP, a written bit or a read bit through a request/acknowledge handshake. Transmit bytes come from an external transmit FIFO, and received bytes go to an external receive FIFO.

As each entry finishes, the block sets that entry's done flag. It raises sticky interrupt flags for start, byte completion, acknowledge error, receive timeout, end of list and stop completion. Each flag can be masked and is cleared by writing one. An acknowledge mismatch or a receive timeout ends the run early and returns the sequencer to idle. The bus-phase code output lets software or a debugger see what the master is doing.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `main_state` is 0, `eng_req` is 0, and all raw flags and done flags are 0.
- R2: A command word is {op[13:11], ack_chk[10], ack_exp[9], ack_val[8], count[7:0]}. A `go` pulse while idle clears every done flag and runs entries in order from entry 0. Each entry that completes sets its own done flag.
- R3: Opcode 0 issues an engine START request (eng_op 0). When the engine acknowledges it, the block sets raw flag bit 0 (start).
- R4: Opcode 1 (write) transfers `count` bytes. For each byte it pops one byte from the transmit FIFO, sends it MSB first as write-bit requests (eng_op 2), then reads the acknowledge with a read-bit request (eng_op 3). A count of 0 completes the entry with no transfer.
- R5: If ack_chk is set on a write and the received acknowledge bit differs from ack_exp, the block sets raw bit 2, stops issuing commands and goes idle, and the failing entry's done flag stays 0. With ack_chk clear, the acknowledge value has no effect.
- R6: Opcode 2 (read) receives `count` bytes MSB first and pushes each byte to the receive FIFO. After each byte it sends the entry's ack_val as one write bit.
- R7: Every byte written or read sets raw bit 1.
- R8: Opcode 3 issues a STOP request (eng_op 1). When it completes, the block sets raw bit 5 and the sequence continues with the next entry.
- R9: Opcode 4, and the unused codes 5 to 7, mark the entry done, set raw bit 4 and end the run; later entries are not executed. Completing entry 15 also ends the run.
- R10: If the bit phase of one received byte lasts more than `rx_timeout` cycles, the block sets raw bit 3 and goes idle without completing the entry.
- R11: Raw flags stay set until a one is written to the matching `irq_clr` bit (a new event in the same cycle wins). `irq_stat` is raw AND `irq_en`, and `irq` is the OR of `irq_stat`.
- R12: `main_state` reports 0 when idle or between steps, 1 and 2 for the first write byte after a START and its acknowledge, 3 while receiving bits, 4 and 5 for later write bits and for sending the read acknowledge, and 6 while waiting for a write acknowledge.
- R13: While `eng_req` is high and not yet acknowledged, `eng_op` and `eng_wbit` stay stable. The only exception is a timeout abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for a command entry |
| cmd_addr | input | 4 | Entry index for the write |
| cmd_wdata | input | 14 | Command word |
| go | input | 1 | Start pulse, taken only when idle |
| busy | output | 1 | Sequence running |
| cmd_done | output | 16 | Per-entry done flags |
| main_state | output | 3 | Bus-phase code |
| eng_req | output | 1 | Request to bit engine |
| eng_op | output | 2 | 0 START, 1 STOP, 2 write bit, 3 read bit |
| eng_wbit | output | 1 | Bit value for a write-bit request |
| eng_ack | input | 1 | One-cycle completion from engine |
| eng_rbit | input | 1 | Bit sampled by engine, valid with eng_ack |
| tx_data | input | 8 | Head of transmit FIFO |
| tx_pop | output | 1 | Take the head byte of the transmit FIFO |
| rx_push | output | 1 | Receive byte valid |
| rx_data | output | 8 | Received byte |
| rx_timeout | input | 20 | Receive bit-phase limit in cycles |
| irq_en | input | 6 | Flag enables |
| irq_clr | input | 6 | Write-one-to-clear strobes |
| irq_raw | output | 6 | Raw flags |
| irq_stat | output | 6 | Masked flags |
| irq | output | 1 | Any masked flag set |

## Verification
The early exits are the hardest situations to reach from the ports: an acknowledge mismatch in the middle of a multi-byte write, and a receive byte that never finishes. The bench's engine model answers each request after a random latency. It returns a programmable acknowledge level on write-acknowledge requests and can be told to withhold every read bit. This lets the stimulus stop a run partway through a list and then confirm that no later STOP was issued and that the failing entry was never marked done. Random write and read lists of varying length, mixed with acknowledge values, then confirm the byte ordering and the acknowledge bits returned.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
   localparam int CNT_W = 8;
   localparam int NIRQ  = 6;

   localparam logic [2:0] OP_RESTART = 3'd0;
   localparam logic [2:0] OP_WRITE   = 3'd1;
   localparam logic [2:0] OP_READ    = 3'd2;
   localparam logic [2:0] OP_STOP    = 3'd3;

   localparam int IRQ_START  = 0;
   localparam int IRQ_BYTE   = 1;
   localparam int IRQ_ACKERR = 2;
   localparam int IRQ_TMO    = 3;
   localparam int IRQ_END    = 4;
   localparam int IRQ_STOPD  = 5;

   typedef struct packed {
      logic [2:0]       op;
      logic             ack_chk;
      logic             ack_exp;
      logic             ack_val;
      logic [CNT_W-1:0] count;
   } cmd_t;

   typedef enum logic [1:0] {
      ENG_START = 2'd0,
      ENG_STOP  = 2'd1,
      ENG_WBIT  = 2'd2,
      ENG_RBIT  = 2'd3
   } eng_op_e;

   typedef enum logic [3:0] {
      S_IDLE, S_DECODE, S_START, S_STOP,
      S_TXBIT, S_TXACK, S_RXBIT, S_RXACK
   } seq_st_e;

   localparam logic [2:0] PH_IDLE   = 3'd0;
   localparam logic [2:0] PH_ADDR   = 3'd1;
   localparam logic [2:0] PH_ADDRAK = 3'd2;
   localparam logic [2:0] PH_RX     = 3'd3;
   localparam logic [2:0] PH_TX     = 3'd4;
   localparam logic [2:0] PH_SENDAK = 3'd5;
   localparam logic [2:0] PH_WAITAK = 3'd6;
endpackage

// File: rtl/i2c_seq_cmd_store.sv
module i2c_seq_cmd_store
   import i2c_seq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  cmd_t             wdata,
   input  logic [AW-1:0]    raddr,
   input  logic             set_done,
   input  logic             clr_all,
   output cmd_t             rdata,
   output logic [DEPTH-1:0] done
);
   cmd_t ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      cmd_t m_q;
      logic d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q <= '0;
            d_q <= 1'b0;
         end else begin
            if (we && waddr == AW'(i)) m_q <= wdata;
            if (clr_all)                                  d_q <= 1'b0;
            else if (set_done && raddr == AW'(i))         d_q <= 1'b1;
            else if (we && waddr == AW'(i))               d_q <= 1'b0;
         end
      end
      assign ent[i]  = m_q;
      assign done[i] = d_q;
   end

   assign rdata = ent[raddr];

   // R2: a new run starts with every done flag cleared
   a_r2_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !set_done) |=> (done == '0));
endmodule

// File: rtl/i2c_seq_irq_bank.sv
module i2c_seq_irq_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] raw,
   output logic [N-1:0] stat,
   output logic         any
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      r_q <= 1'b0;
         else if (set[i]) r_q <= 1'b1;
         else if (clr[i]) r_q <= 1'b0;
      end
      assign raw[i] = r_q;

      // R11: a clear with no new event drops the flag
      a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !raw[i]);
      // R11: flags are sticky without a clear
      a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (raw[i] && !clr[i]) |=> raw[i]);
   end

   assign stat = raw & en;
   assign any  = |stat;
endmodule

// File: rtl/i2c_seq_rx_wdog.sv
module i2c_seq_rx_wdog #(
   parameter int W  = 20,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         fire
);
   if (EN) begin : g_on
      logic [W:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt <= '0;
         else if (clr) cnt <= '0;
         else if (run) cnt <= cnt + 1'b1;
      end
      assign fire = run && (cnt == {1'b0, limit});

      // R10: a running byte never counts past its limit
      a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
         run |-> (cnt <= {1'b0, limit}));
   end else begin : g_off
      assign fire = 1'b0;
   end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
   import i2c_seq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int TMO_W  = 20,
   parameter bit TMO_EN = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $bits(cmd_t)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [CW-1:0]    cmd_wdata,
   input  logic             go,
   output logic             busy,
   output logic [DEPTH-1:0] cmd_done,
   output logic [2:0]       main_state,
   output logic             eng_req,
   output logic [1:0]       eng_op,
   output logic             eng_wbit,
   input  logic             eng_ack,
   input  logic             eng_rbit,
   input  logic [7:0]       tx_data,
   output logic             tx_pop,
   output logic             rx_push,
   output logic [7:0]       rx_data,
   input  logic [TMO_W-1:0] rx_timeout,
   input  logic [NIRQ-1:0]  irq_en,
   input  logic [NIRQ-1:0]  irq_clr,
   output logic [NIRQ-1:0]  irq_raw,
   output logic [NIRQ-1:0]  irq_stat,
   output logic             irq
);
   if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("TMO_W must be at least 1");
   end

   seq_st_e          st, st_n;
   logic [AW-1:0]    pc, pc_n;
   logic [CNT_W-1:0] left, left_n;
   logic [2:0]       bitc, bit_n;
   logic [7:0]       sh, sh_n;
   logic             addr_ph, addr_n;
   logic             push_q, push_n;
   logic [7:0]       rxd_q, rxd_n;
   logic             done_set, done_clr, tmo_clr, tmo_fire, adv;
   logic [NIRQ-1:0]  irq_set;
   cmd_t             cur;

   i2c_seq_cmd_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .we(cmd_we), .waddr(cmd_addr),
      .wdata(cmd_t'(cmd_wdata)), .raddr(pc), .set_done(done_set),
      .clr_all(done_clr), .rdata(cur), .done(cmd_done));

   i2c_seq_irq_bank #(.N(NIRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .en(irq_en),
      .raw(irq_raw), .stat(irq_stat), .any(irq));

   i2c_seq_rx_wdog #(.W(TMO_W), .EN(TMO_EN)) u_wdog (
      .clk(clk), .rst_n(rst_n), .clr(tmo_clr || !busy),
      .run(st == S_RXBIT), .limit(rx_timeout), .fire(tmo_fire));

   always_comb begin
      st_n = st; pc_n = pc; left_n = left; bit_n = bitc; sh_n = sh;
      addr_n = addr_ph; push_n = 1'b0; rxd_n = rxd_q;
      tx_pop = 1'b0; done_set = 1'b0; done_clr = 1'b0; tmo_clr = 1'b0;
      irq_set = '0; adv = 1'b0;
      case (st)
         S_IDLE: if (go) begin
            st_n = S_DECODE; pc_n = '0; done_clr = 1'b1; addr_n = 1'b0;
         end
         S_DECODE: begin
            case (cur.op)
               OP_RESTART: st_n = S_START;
               OP_WRITE: begin
                  if (cur.count == '0) adv = 1'b1;
                  else begin
                     left_n = cur.count; sh_n = tx_data; tx_pop = 1'b1;
                     bit_n = 3'd7; st_n = S_TXBIT;
                  end
               end
               OP_READ: begin
                  if (cur.count == '0) adv = 1'b1;
                  else begin
                     left_n = cur.count; bit_n = 3'd7; tmo_clr = 1'b1;
                     st_n = S_RXBIT;
                  end
               end
               OP_STOP: st_n = S_STOP;
               default: begin
                  done_set = 1'b1; irq_set[IRQ_END] = 1'b1; st_n = S_IDLE;
               end
            endcase
         end
         S_START: if (eng_ack) begin
            irq_set[IRQ_START] = 1'b1; addr_n = 1'b1; adv = 1'b1;
         end
         S_STOP: if (eng_ack) begin
            irq_set[IRQ_STOPD] = 1'b1; addr_n = 1'b0; adv = 1'b1;
         end
         S_TXBIT: if (eng_ack) begin
            if (bitc == 3'd0) st_n = S_TXACK;
            else begin
               sh_n = {sh[6:0], 1'b0}; bit_n = bitc - 3'd1;
            end
         end
         S_TXACK: if (eng_ack) begin
            irq_set[IRQ_BYTE] = 1'b1;
            if (cur.ack_chk && (eng_rbit != cur.ack_exp)) begin
               irq_set[IRQ_ACKERR] = 1'b1; st_n = S_IDLE;
            end else begin
               addr_n = 1'b0;
               if (left == CNT_W'(1)) adv = 1'b1;
               else begin
                  left_n = left - 1'b1; sh_n = tx_data; tx_pop = 1'b1;
                  bit_n = 3'd7; st_n = S_TXBIT;
               end
            end
         end
         S_RXBIT: begin
            if (tmo_fire) begin
               irq_set[IRQ_TMO] = 1'b1; st_n = S_IDLE;
            end else if (eng_ack) begin
               sh_n = {sh[6:0], eng_rbit};
               if (bitc == 3'd0) begin
                  push_n = 1'b1; rxd_n = {sh[6:0], eng_rbit}; st_n = S_RXACK;
               end else bit_n = bitc - 3'd1;
            end
         end
         S_RXACK: if (eng_ack) begin
            irq_set[IRQ_BYTE] = 1'b1;
            if (left == CNT_W'(1)) adv = 1'b1;
            else begin
               left_n = left - 1'b1; bit_n = 3'd7; tmo_clr = 1'b1;
               st_n = S_RXBIT;
            end
         end
         default: st_n = S_IDLE;
      endcase
      if (adv) begin
         done_set = 1'b1;
         if (pc == AW'(DEPTH - 1)) st_n = S_IDLE;
         else begin
            pc_n = pc + 1'b1; st_n = S_DECODE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; pc <= '0; left <= '0; bitc <= '0; sh <= '0;
         addr_ph <= 1'b0; push_q <= 1'b0; rxd_q <= '0;
      end else begin
         st <= st_n; pc <= pc_n; left <= left_n; bitc <= bit_n; sh <= sh_n;
         addr_ph <= addr_n; push_q <= push_n; rxd_q <= rxd_n;
      end
   end

   always_comb begin
      case (st)
         S_START: eng_op = ENG_START;
         S_STOP:  eng_op = ENG_STOP;
         S_TXBIT, S_RXACK: eng_op = ENG_WBIT;
         default: eng_op = ENG_RBIT;
      endcase
      case (st)
         S_TXBIT: main_state = addr_ph ? PH_ADDR : PH_TX;
         S_TXACK: main_state = addr_ph ? PH_ADDRAK : PH_WAITAK;
         S_RXBIT: main_state = PH_RX;
         S_RXACK: main_state = PH_SENDAK;
         default: main_state = PH_IDLE;
      endcase
   end

   assign eng_req  = st inside {S_START, S_STOP, S_TXBIT, S_TXACK, S_RXBIT, S_RXACK};
   assign eng_wbit = (st == S_TXBIT) ? sh[7] : (st == S_RXACK) ? cur.ack_val : 1'b1;
   assign busy     = (st != S_IDLE);
   assign rx_push  = push_q;
   assign rx_data  = rxd_q;

   // R13: a pending request holds its operation until acknowledged
   a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_ack && !tmo_fire) |=>
         (eng_req && $stable(eng_op) && $stable(eng_wbit)));
   // R4: transmit bytes are taken only for a write entry
   a_r4_pop_write: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> (cur.op == OP_WRITE));
   // R5: an acknowledge error ends the run on the next cycle
   a_r5_ackerr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set[IRQ_ACKERR] |=> !busy);
   // R12: idle always reports phase code 0
   a_r12_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (main_state == PH_IDLE));
endmodule

// File: tb/i2c_cmd_seq_bench.sv
module i2c_cmd_seq_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic cmd_we = 0, go = 0, eng_ack, eng_rbit;
   logic [3:0] cmd_addr = 0;
   logic [13:0] cmd_wdata = 0;
   logic busy, eng_req, eng_wbit, tx_pop, rx_push, irq;
   logic [15:0] cmd_done;
   logic [2:0] main_state;
   logic [1:0] eng_op;
   logic [7:0] tx_data, rx_data;
   logic [19:0] rx_timeout = 20'hFFFFF;
   logic [5:0] irq_en = 0, irq_clr = 0, irq_raw, irq_stat;

   i2c_cmd_seq u_i2c_cmd_seq (.*);

   int total = 0, fails = 0;
   logic [7:0] tx_mem [256];
   logic [7:0] slave_mem [256];
   logic [7:0] tx_rd, s_rd;
   logic [2:0] s_bit, txb;
   logic [7:0] tx_cur;
   logic [7:0] tx_log [1024];
   logic [7:0] rx_log [1024];
   logic       ack_log [1024];
   int tx_n, rx_n, ack_n, start_n, stop_n, viol;
   int state_cnt [8];
   logic slave_ack = 0, stall_rd = 0;
   int lat;
   logic p_req, p_ack, p_wbit;
   logic [1:0] p_op;

   assign tx_data = tx_mem[tx_rd];

   // bit engine and FIFO models
   always @(posedge clk) begin
      if (!rst_n) begin
         eng_ack <= 0; eng_rbit <= 1; lat <= 1; tx_rd <= 0; s_rd <= 0; s_bit <= 0;
         txb <= 0; tx_cur <= 0; tx_n <= 0; rx_n <= 0; ack_n <= 0;
         start_n <= 0; stop_n <= 0; viol <= 0; p_req <= 0; p_ack <= 0;
         p_wbit <= 0; p_op <= 0;
         for (int i = 0; i < 8; i++) state_cnt[i] <= 0;
      end else begin
         eng_ack <= 0;
         state_cnt[main_state] <= state_cnt[main_state] + 1;
         if (tx_pop) tx_rd <= tx_rd + 1;
         if (rx_push) begin rx_log[rx_n] <= rx_data; rx_n <= rx_n + 1; end
         if (p_req && !p_ack && eng_req && (eng_op != p_op || eng_wbit != p_wbit))
            viol <= viol + 1;
         p_req <= eng_req; p_ack <= eng_ack; p_op <= eng_op; p_wbit <= eng_wbit;
         if (eng_req && !eng_ack && !(stall_rd && eng_op == 2'd3 && main_state == 3'd3)) begin
            if (lat != 0) lat <= lat - 1;
            else begin
               lat <= int'($urandom_range(0, 3));
               eng_ack <= 1;
               case (eng_op)
                  2'd0: start_n <= start_n + 1;
                  2'd1: stop_n <= stop_n + 1;
                  2'd2: begin
                     if (main_state == 3'd5) begin
                        ack_log[ack_n] <= eng_wbit; ack_n <= ack_n + 1;
                     end else begin
                        tx_cur <= {tx_cur[6:0], eng_wbit};
                        txb <= txb + 1;
                        if (txb == 3'd7) begin
                           tx_log[tx_n] <= {tx_cur[6:0], eng_wbit}; tx_n <= tx_n + 1;
                        end
                     end
                  end
                  default: begin
                     if (main_state == 3'd3) begin
                        eng_rbit <= slave_mem[s_rd][3'd7 - s_bit];
                        s_bit <= s_bit + 1;
                        if (s_bit == 3'd7) s_rd <= s_rd + 1;
                     end else eng_rbit <= slave_ack;
                  end
               endcase
            end
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [13:0] mk(int op, bit c, bit e, bit v, int n);
      return {3'(op), c, e, v, 8'(n)};
   endfunction

   task automatic put(int idx, logic [13:0] w);
      @(negedge clk); cmd_we = 1; cmd_addr = 4'(idx); cmd_wdata = w;
      @(negedge clk); cmd_we = 0;
   endtask

   task automatic clr_all();
      @(negedge clk); irq_clr = '1; @(negedge clk); irq_clr = '0;
   endtask

   task automatic run_list();
      int g = 0;
      @(negedge clk); go = 1; @(negedge clk); go = 0;
      while (busy && g < 20000) begin @(negedge clk); g++; end
      if (g >= 20000) chk("R2 run did not finish", 1, 0);
      @(negedge clk);
   endtask

   // write/read list: START, address WRITE 1, body, STOP, END
   task automatic rand_txn(bit is_rd, int n, bit av);
      int t0, r0, a0, x0; logic [7:0] tp, sp;
      put(0, mk(0,0,0,0,0)); put(1, mk(1,1,0,0,1));
      put(2, is_rd ? mk(2,0,0,av,n) : mk(1,1,0,0,n));
      put(3, mk(3,0,0,0,0)); put(4, mk(4,0,0,0,0));
      slave_ack = 0; t0 = tx_n; r0 = rx_n; a0 = ack_n; tp = tx_rd; sp = s_rd; x0 = stop_n;
      run_list();
      chk("R2 random list done", int'(cmd_done), 16'h001F);
      chk("R8 random stop", stop_n - x0, 1);
      chk("R4 random tx count", tx_n - t0, is_rd ? 1 : n + 1);
      for (int k = 0; k < (is_rd ? 1 : n + 1); k++)
         chk("R4 random tx byte", int'(tx_log[t0 + k]), int'(tx_mem[8'(tp + 8'(k))]));
      if (is_rd) begin
         chk("R6 random rx count", rx_n - r0, n);
         for (int k = 0; k < n; k++) begin
            chk("R6 random rx byte", int'(rx_log[r0 + k]), int'(slave_mem[8'(sp + 8'(k))]));
            chk("R6 random ack value", int'(ack_log[a0 + k]), int'(av));
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int s0, t0, r0, a0, x0, st1, st2, st3, st4, st5, st6;
      logic [7:0] tp, sp;
      s0 = $urandom(32'd4242);
      for (int i = 0; i < 256; i++) begin
         tx_mem[i] = 8'($urandom); slave_mem[i] = 8'($urandom);
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 busy", busy, 0); chk("R1 main_state", main_state, 0);
      chk("R1 eng_req", eng_req, 0); chk("R1 raw", irq_raw, 0); chk("R1 done", cmd_done, 0);

      // write list
      put(0, mk(0,0,0,0,0)); put(1, mk(1,1,0,0,3)); put(2, mk(3,0,0,0,0)); put(3, mk(4,0,0,0,0));
      t0 = tx_n; tp = tx_rd; x0 = stop_n; a0 = start_n;
      st1 = state_cnt[1]; st2 = state_cnt[2]; st4 = state_cnt[4]; st6 = state_cnt[6];
      run_list();
      chk("R3 start request", start_n - a0, 1);
      chk("R3 start flag", irq_raw[0], 1);
      chk("R4 bytes sent", tx_n - t0, 3);
      for (int k = 0; k < 3; k++) chk("R4 byte MSB first", tx_log[t0+k], tx_mem[8'(tp + 8'(k))]);
      chk("R4 fifo pops", int'(8'(tx_rd - tp)), 3);
      chk("R7 byte flag", irq_raw[1], 1);
      chk("R8 stop request", stop_n - x0, 1);
      chk("R8 stop flag", irq_raw[5], 1);
      chk("R9 end flag", irq_raw[4], 1);
      chk("R5 no ack error", irq_raw[2], 0);
      chk("R2 done flags", cmd_done, 16'h000F);
      chk("R12 address phase seen", int'(state_cnt[1] > st1 && state_cnt[2] > st2), 1);
      chk("R12 data phase seen", int'(state_cnt[4] > st4 && state_cnt[6] > st6), 1);

      // R2: done flags cleared by a new go
      put(0, mk(4,0,0,0,0));
      run_list();
      chk("R2 done cleared on go", cmd_done, 16'h0001);

      // read list
      clr_all();
      put(0, mk(0,0,0,0,0)); put(1, mk(1,0,0,0,1)); put(2, mk(2,0,0,0,4));
      put(3, mk(2,0,0,1,1)); put(4, mk(3,0,0,0,0)); put(5, mk(4,0,0,0,0));
      r0 = rx_n; a0 = ack_n; sp = s_rd; st3 = state_cnt[3]; st5 = state_cnt[5];
      run_list();
      chk("R6 bytes received", rx_n - r0, 5);
      for (int k = 0; k < 5; k++) chk("R6 rx byte", rx_log[r0+k], slave_mem[8'(sp + 8'(k))]);
      chk("R6 ack count", ack_n - a0, 5);
      for (int k = 0; k < 5; k++) chk("R6 ack value", ack_log[a0+k], (k == 4) ? 1 : 0);
      chk("R2 read done flags", cmd_done, 16'h003F);
      chk("R12 receive phases seen", int'(state_cnt[3] > st3 && state_cnt[5] > st5), 1);

      // R5: acknowledge error stops the list
      clr_all();
      put(0, mk(0,0,0,0,0)); put(1, mk(1,1,0,0,2)); put(2, mk(3,0,0,0,0)); put(3, mk(4,0,0,0,0));
      slave_ack = 1; tp = tx_rd; x0 = stop_n;
      run_list();
      chk("R5 ack error flag", irq_raw[2], 1);
      chk("R5 failing entry not done", cmd_done, 16'h0001);
      chk("R5 no stop after error", stop_n - x0, 0);
      chk("R5 one byte taken", int'(8'(tx_rd - tp)), 1);
      chk("R5 idle after error", busy, 0);
      // R5: check disabled ignores a NACK
      clr_all();
      put(1, mk(1,0,0,0,2));
      run_list();
      chk("R5 unchecked nack ignored", irq_raw[2], 0);
      chk("R5 unchecked done", cmd_done, 16'h000F);
      // R5: expected value 1 matches
      clr_all();
      put(1, mk(1,1,1,0,2));
      run_list();
      chk("R5 expected nack matches", irq_raw[2], 0);
      chk("R5 expected nack done", cmd_done, 16'h000F);
      slave_ack = 0;

      // R10: receive timeout
      clr_all();
      rx_timeout = 20'd40; stall_rd = 1;
      put(0, mk(0,0,0,0,0)); put(1, mk(2,0,0,0,2)); put(2, mk(3,0,0,0,0)); put(3, mk(4,0,0,0,0));
      r0 = rx_n; x0 = stop_n;
      run_list();
      chk("R10 timeout flag", irq_raw[3], 1);
      chk("R10 read not done", cmd_done, 16'h0001);
      chk("R10 no stop", stop_n - x0, 0);
      chk("R10 no byte pushed", rx_n - r0, 0);
      stall_rd = 0; rx_timeout = 20'hFFFFF;

      // R9: unused opcode ends the run, later entries skipped
      clr_all();
      put(0, mk(0,0,0,0,0)); put(1, mk(5,0,0,0,0)); put(2, mk(3,0,0,0,0));
      x0 = stop_n;
      run_list();
      chk("R9 unused opcode acts as end", cmd_done, 16'h0003);
      chk("R9 end flag", irq_raw[4], 1);
      chk("R9 later stop skipped", stop_n - x0, 0);

      // R9 and R4: full list of 16, zero-count writes, ends after entry 15
      clr_all();
      put(0, mk(0,0,0,0,0));
      for (int i = 1; i < 15; i++) put(i, mk(1,1,0,0,0));
      put(15, mk(3,0,0,0,0));
      tp = tx_rd; x0 = stop_n;
      run_list();
      chk("R9 all sixteen done", cmd_done, 16'hFFFF);
      chk("R4 zero count pops nothing", int'(8'(tx_rd - tp)), 0);
      chk("R7 no byte flag on zero count", irq_raw[1], 0);
      chk("R9 final stop", stop_n - x0, 1);
      chk("R9 idle after last entry", busy, 0);

      // R11: masking and clearing
      clr_all();
      chk("R11 raw cleared", irq_raw, 0);
      put(0, mk(4,0,0,0,0));
      run_list();
      chk("R11 raw end set", irq_raw, 6'h10);
      chk("R11 masked off", irq, 0);
      chk("R11 stat masked off", irq_stat, 0);
      @(negedge clk); irq_en = 6'h10; #1;
      chk("R11 irq enabled", irq, 1);
      chk("R11 stat enabled", irq_stat, 6'h10);
      @(negedge clk); irq_clr = 6'h10; @(negedge clk); irq_clr = 0;
      chk("R11 clear drops raw", irq_raw, 0);
      chk("R11 irq after clear", irq, 0);
      irq_en = 0;

      // random lists
      for (int it = 0; it < 8; it++)
         rand_txn(1'($urandom), int'($urandom_range(1, 5)), 1'($urandom));

      chk("R13 handshake held stable", viol, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule